// File: doc/BRIEF.md
# SPI Flash Identification Responder

This block is the target side of the product identification exchange of a small serial flash memory. A fast system clock oversamples the three SPI pins (serial clock, serial data in, active-low chip select). While the chip is selected the block collects an eight-bit instruction and counts three dummy bytes. It then streams a three-byte identity on the serial data output. The identity is the first manufacturer code, a density-dependent device code and a second manufacturer code. The identity repeats for as long as the chip stays selected.

The output is modelled as a data bit plus an output enable, where the enable low stands for a released, high-impedance line. Any instruction other than the identification opcode parks the block in a silent state until the next deselect. Both common clock polarities (idle low and idle high) are accepted without configuration.

Top module: `spi_id_responder`

## Requirements
- R1: The identification opcode is 8'hAB, taken MSB first as one bit per rising serial-clock edge over eight rising edges.
- R2: After the opcode, exactly 24 further rising edges (three dummy bytes) pass before any identity bit is driven; dummy input values have no effect.
- R3: The input bit is sampled on the rising serial-clock edge, and the output bit changes only on the falling edge, staying stable across the following rising edge.
- R4: The identity is sent as 8'h9D, then the device code, then 8'h7F, each byte MSB first. The first identity bit appears after the first falling edge that follows the 32nd rising edge.
- R5: The device code is the parameter DEV_ID; the legal values are 8'h7B (512 Kbit), 8'h7C (1 Mbit), 8'h7D (2 Mbit) and 8'h7E (4 Mbit).
- R6: After the last bit of 8'h7F, the next falling edge restarts the stream at the MSB of 8'h9D, indefinitely while selected.
- R7: The output enable is low whenever the chip is deselected and throughout the opcode and dummy phases.
- R8: Idle-low and idle-high clock polarity both work; a falling edge seen before the first rising edge of a selection advances no counter.
- R9: Any opcode other than 8'hAB leaves the output enable low for the rest of that selection.
- R10: A rising chip select at any bit position drops the output enable at once. The next selection starts again with the opcode phase.
- R11: After the asynchronous reset the output enable and the output bit are low.
- R12: Pins pass through two-flop synchronizers; the system clock must run at least four times faster than the serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System oversampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data into the block |
| cs_ni | input | 1 | Active-low chip select |
| so_o | output | 1 | Serial data out of the block |
| so_oe_o | output | 1 | Output enable for so_o; low models high impedance |

## Verification
The assertions assume the host holds each serial-clock level for several system clocks, so every edge is seen once after the synchronizers. They also assume the data input is steady around each rising edge, and that chip select changes only while the serial clock is idle at the start of a selection. The bench holds every serial-clock half period at eight system clocks and changes data only with the falling edge. It raises chip select only after a full bit slot, and covers both idle polarities, a wrong opcode and aborts in the opcode and data phases.

// File: rtl/spi_id_pkg.sv
package spi_id_pkg;
  localparam logic [7:0] ID_OPCODE   = 8'hAB;
  localparam logic [7:0] MFR_FIRST   = 8'h9D;
  localparam logic [7:0] MFR_SECOND  = 8'h7F;

  localparam logic [7:0] DEV_512K    = 8'h7B;
  localparam logic [7:0] DEV_1M      = 8'h7C;
  localparam logic [7:0] DEV_2M      = 8'h7D;
  localparam logic [7:0] DEV_4M      = 8'h7E;

  typedef enum logic [1:0] {
    ST_CMD    = 2'd0,
    ST_DUMMY  = 2'd1,
    ST_DATA   = 2'd2,
    ST_IGNORE = 2'd3
  } id_state_e;
endpackage

// File: rtl/spi_id_sync.sv
module spi_id_sync #(
  parameter int          WIDTH      = 3,
  parameter int          STAGES     = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/spi_id_edge.sv
module spi_id_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_s_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_d_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d_q <= 1'b0;
    else         sck_d_q <= sck_s_i;
  end
  assign rise_o = sck_s_i & ~sck_d_q;
  assign fall_o = ~sck_s_i & sck_d_q;
endmodule

// File: rtl/spi_id_stream.sv
module spi_id_stream #(
  parameter logic [7:0] DEV_ID = spi_id_pkg::DEV_1M,
  parameter int         ID_BITS = 24,
  parameter int         IDX_W   = 5
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             bit_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ID_BITS - 1);
  logic [ID_BITS-1:0] stream;
  assign stream = {spi_id_pkg::MFR_FIRST, DEV_ID, spi_id_pkg::MFR_SECOND};
  assign bit_o  = stream[LAST_IDX - idx_i];
endmodule

// File: rtl/spi_id_core.sv
module spi_id_core
  import spi_id_pkg::*;
#(
  parameter int OPC_BITS   = 8,
  parameter int DUMMY_BITS = 24,
  parameter int ID_BITS    = 24,
  parameter int CNT_W      = 5,
  parameter int IDX_W      = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             si_s_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             id_bit_i,
  output id_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             so_o,
  output logic             oe_o
);
  localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_BITS - 1);
  localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST   = IDX_W'(ID_BITS - 1);

  id_state_e            state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [OPC_BITS-1:0]  opc_q;
  logic [OPC_BITS-1:0]  opc_next;
  logic                 so_q, oe_q;

  assign opc_next = {opc_q[OPC_BITS-2:0], si_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      idx_q   <= '0;
      opc_q   <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else if (cs_s_i) begin
      state_q <= ST_CMD;
      cnt_q   <= '0;
      idx_q   <= '0;
      opc_q   <= '0;
      so_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_CMD: if (rise_i) begin
          opc_q <= opc_next;
          if (cnt_q == OPC_LAST) begin
            cnt_q   <= '0;
            state_q <= (opc_next == ID_OPCODE) ? ST_DUMMY : ST_IGNORE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DUMMY: if (rise_i) begin
          if (cnt_q == DUMMY_LAST) begin
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: if (fall_i) begin
          so_q  <= id_bit_i;
          oe_q  <= 1'b1;
          idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign idx_o   = idx_q;
  assign so_o    = so_q;
  assign oe_o    = oe_q;
endmodule

// File: rtl/spi_id_responder.sv
module spi_id_responder
  import spi_id_pkg::*;
#(
  parameter logic [7:0] DEV_ID      = DEV_1M,
  parameter int         SYNC_STAGES = 2,
  parameter int         DUMMY_BYTES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic si_i,
  input  logic cs_ni,
  output logic so_o,
  output logic so_oe_o
);
  localparam int OPC_BITS   = 8;
  localparam int DUMMY_BITS = DUMMY_BYTES * 8;
  localparam int ID_BITS    = 24;
  localparam int CNT_MAX    = (DUMMY_BITS > OPC_BITS) ? DUMMY_BITS : OPC_BITS;
  localparam int CNT_W      = $clog2(CNT_MAX);
  localparam int IDX_W      = $clog2(ID_BITS);

  logic [2:0]       pins_s;
  logic             sck_s, si_s, cs_s;
  logic             sck_rise, sck_fall;
  logic             id_bit, oe_q;
  id_state_e        state;
  logic [CNT_W-1:0] bit_cnt;
  logic [IDX_W-1:0] out_idx;

  spi_id_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, si_i, sck_i}),
    .q_o   (pins_s)
  );
  assign sck_s = pins_s[0];
  assign si_s  = pins_s[1];
  assign cs_s  = pins_s[2];

  spi_id_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_s_i(sck_s),
    .rise_o (sck_rise),
    .fall_o (sck_fall)
  );

  spi_id_stream #(.DEV_ID(DEV_ID), .ID_BITS(ID_BITS), .IDX_W(IDX_W)) i_stream (
    .idx_i(out_idx),
    .bit_o(id_bit)
  );

  spi_id_core #(
    .OPC_BITS  (OPC_BITS),
    .DUMMY_BITS(DUMMY_BITS),
    .ID_BITS   (ID_BITS),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) i_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_s_i  (cs_s),
    .si_s_i  (si_s),
    .rise_i  (sck_rise),
    .fall_i  (sck_fall),
    .id_bit_i(id_bit),
    .state_o (state),
    .cnt_o   (bit_cnt),
    .idx_o   (out_idx),
    .so_o    (so_o),
    .oe_o    (oe_q)
  );

  // raw select gates the enable so release needs no clock
  assign so_oe_o = oe_q & ~cs_ni;
endmodule

// File: rtl/spi_id_checker.sv
module spi_id_checker
  import spi_id_pkg::*;
#(
  parameter int CNT_W   = 5,
  parameter int IDX_W   = 5,
  parameter int ID_BITS = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_s,
  input logic             rise,
  input logic             fall,
  input id_state_e        state,
  input logic [CNT_W-1:0] cnt,
  input logic [IDX_W-1:0] idx,
  input logic             so_oe_o
);
  a_r1_opcode_counts_rises: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_CMD && rise && !cs_s && cnt < CNT_W'(7)) |=> cnt == $past(cnt) + 1'b1);

  a_r2_data_only_after_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && $past(state) != ST_DATA) |-> $past(state) == ST_DUMMY);

  a_r6_index_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx <= IDX_W'(ID_BITS - 1));

  a_r7_enable_only_in_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    so_oe_o |-> state == ST_DATA);

  a_r8_fall_holds_counter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_CMD || state == ST_DUMMY) && fall && !cs_s) |=> $stable(cnt));

  a_r9_ignore_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE && !cs_s) |=> state == ST_IGNORE);

  a_r10_deselect_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> state == ST_CMD);
endmodule

bind spi_id_responder spi_id_checker #(.CNT_W(CNT_W), .IDX_W(IDX_W), .ID_BITS(ID_BITS)) i_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_s   (cs_s),
  .rise   (sck_rise),
  .fall   (sck_fall),
  .state  (state),
  .cnt    (bit_cnt),
  .idx    (out_idx),
  .so_oe_o(so_oe_o)
);

// File: tb/test_spi_id_responder.sv
`timescale 1ns/1ps
module test_spi_id_responder;
  localparam logic [7:0] DEV  = 8'h7E;  // R5: 4 Mbit code
  localparam int         HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, si = 1'b0, cs_ni = 1'b1;
  logic so, so_oe;
  int   checks = 0, fails = 0, cycles = 0;
  logic quiet = 1'b1;
  logic [23:0] stream = {8'h9D, DEV, 8'h7F};

  always #2.5 clk = ~clk;

  spi_id_responder #(.DEV_ID(DEV)) i_spi_id_responder (
    .clk_i(clk), .rst_ni(rst_ni), .sck_i(sck), .si_i(si), .cs_ni(cs_ni),
    .so_o(so), .so_oe_o(so_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // R7: every clock while the model expects a released line
  always @(negedge clk) begin
    cycles++;
    if (rst_ni && quiet) check("R7 idle enable", so_oe, 1'b0);
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic bit_slot(input logic b, input int i, input logic good);
    logic data_ph;
    logic eb;
    data_ph = good && (i >= 32);
    eb = data_ph ? stream[23 - ((i - 32) % 24)] : 1'b0;
    if (data_ph) quiet = 1'b0;
    sck = 1'b0;
    si  = b;
    repeat (HALF) @(negedge clk);
    // R2 R4 R6 R9: value presented before this rising edge
    check(good ? (i < 32 ? "R2 dummy quiet" : (i < 56 ? "R4 id bit" : "R6 loop bit"))
               : "R9 ignored opcode", so_oe, data_ph);
    if (data_ph) check(i < 56 ? "R4 id value" : "R6 loop value", so, eb);
    sck = 1'b1;
    repeat (HALF / 2) @(negedge clk);
    if (data_ph) check("R3 stable over rise", so, eb);
    repeat (HALF - HALF / 2) @(negedge clk);
  endtask

  task automatic txn(input logic mode3, input logic [7:0] opc, input int nbits, input string tag);
    logic good;
    good = (opc == 8'hAB);
    sck = mode3;
    repeat (2) @(negedge clk);
    cs_ni = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++)
      bit_slot((i < 8) ? opc[7 - i] : i[0], i, good);
    if (!mode3) begin
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
    cs_ni = 1'b1;
    #1;
    check({"R10 release ", tag}, so_oe, 1'b0);
    @(negedge clk);
    quiet = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset enable", so_oe, 1'b0);
    check("R11 reset data", so, 1'b0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    txn(1'b0, 8'hAB, 32 + 72, "mode0 R1 R12");   // three full loops
    txn(1'b1, 8'hAB, 32 + 30, "mode3 R8");       // leading fall ignored
    txn(1'b0, 8'h9F, 48, "bad opcode R9");
    txn(1'b1, 8'hAB, 5, "abort opcode");
    txn(1'b0, 8'hAB, 40, "abort data");          // also proves restart after R10
    txn(1'b1, 8'hAB, 20, "abort dummy");
    txn(1'b1, 8'hAB, 32 + 50, "mode3 after aborts R5");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule